// File: doc/BRIEF.md
# Width-Switchable Register and Flag Unit

This block keeps the accumulator, the two index registers and the 8-bit processor status byte of a CPU whose data width and index width each switch between 8 and 16 bits under control of two status flags. A write port updates any of the three registers in the width that the current status selects, and every register write refreshes the zero and negative flags from the bits actually written. A separate status path can load the whole byte or set and clear any group of flags by mask, and a mask test reports whether every selected flag is set.

The index registers are narrowed as a side effect: on any cycle whose resulting status has the index-narrow flag set, the upper bytes of both index registers are cleared. This happens in the same edge as the status change, so the outputs never show a narrow status with stale upper index bytes. Two reset flavours exist. A power-on reset clears everything and loads a fixed status. A warm reset forces the narrow and interrupt-mask flags, clears the decimal flag and leaves the rest alone.

Top module: `regflag_unit`

## Requirements
- R1: While `rst` is high, the next edge sets `acc_q`, `idx_x_q` and `idx_y_q` to 0 and `stat_q` to 8'h34 (interrupt mask bit 2, index-narrow bit 4 and data-narrow bit 5 set).
- R2: With `rst` low and `warm_rst` high, the next edge sets status bits 2, 4 and 5, clears bit 3, keeps the other status bits and `acc_q`, clears the upper bytes of both index registers, and ignores every write and status input of that cycle.
- R3: `wr_sel` encodes 0 = accumulator, 1 = X, 2 = Y, 3 = none. An accumulator write with status bit 5 set replaces only bits 7:0 and keeps bits 15:8; with bit 5 clear it replaces all 16 bits. Encoding 3 changes no register and no flag.
- R4: X and Y writes follow the same rule as R3 with status bit 4 selecting the narrow width.
- R5: A register write sets status bit 1 (zero) when the written width is all zero, otherwise clears it and sets bit 7 (negative) from bit 7 (narrow) or bit 15 (wide) of the written value; bit 7 is clear when bit 1 is set.
- R6: With `st_load` high, the status byte becomes `st_val` at the next edge.
- R7: With `st_load` low, the status becomes (status OR `st_set`) AND NOT `st_clr`; a bit in both masks ends clear.
- R8: Whenever the status after an edge has bit 4 set, bits 15:8 of X and Y are 0 after that same edge.
- R9: `test_hit` is 1 exactly when every bit set in `test_mask` is also set in `stat_q`; an empty mask gives 1.
- R10: A register write and a status operation in the same cycle both take effect on one edge: the write width comes from the status before the edge, the written value's zero and negative results override bits 1 and 7 of the status operation, and the index truncation of R8 applies to a value written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register select: 0 acc, 1 X, 2 Y, 3 none |
| wr_val | input | DATA_W | Value to write |
| st_load | input | 1 | Replace status with `st_val` |
| st_val | input | 8 | Status load value |
| st_set | input | 8 | Status bits to set |
| st_clr | input | 8 | Status bits to clear |
| test_mask | input | 8 | Flags to test together |
| acc_q | output | DATA_W | Accumulator |
| idx_x_q | output | DATA_W | X index register |
| idx_y_q | output | DATA_W | Y index register |
| stat_q | output | 8 | Status byte |
| test_hit | output | 1 | All masked flags set |

## Verification
Every register, flag and truncation result is due on the first clock edge after the inputs that cause it, and `test_hit` follows `stat_q` and `test_mask` without a further register. The bench therefore drives inputs on the falling edge, advances its behavioural model at the next rising edge and compares every output at the following falling edge, one full cycle per operation. Same-cycle combinations of write, status change and truncation are compared the same way, since they all land on that one edge.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  localparam int ST_W = 8;

  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_I = 2;
  localparam int B_D = 3;
  localparam int B_X = 4;
  localparam int B_M = 5;
  localparam int B_V = 6;
  localparam int B_N = 7;

  typedef enum logic [1:0] {
    SEL_ACC  = 2'd0,
    SEL_IX   = 2'd1,
    SEL_IY   = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam logic [ST_W-1:0] FORCE_MASK = ST_W'((1 << B_I) | (1 << B_X) | (1 << B_M));
  localparam logic [ST_W-1:0] PWRON_ST   = FORCE_MASK;
  localparam logic [ST_W-1:0] WARM_CLR   = ST_W'(1 << B_D);
endpackage

// File: rtl/rfu_write_merge.sv
module rfu_write_merge #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic [W-NW-1:0] cur_hi,
  input  logic [W-1:0]    din,
  input  logic            narrow,
  output logic [W-1:0]    merged,
  output logic            is_zero,
  output logic            is_neg
);
  always_comb begin
    if (narrow) begin
      merged  = {cur_hi, din[NW-1:0]};
      is_zero = (din[NW-1:0] == '0);
      is_neg  = din[NW-1];
    end else begin
      merged  = din;
      is_zero = (din == '0);
      is_neg  = din[W-1];
    end
  end
endmodule

// File: rtl/rfu_status.sv
module rfu_status
  import rfu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            warm_rst,
  input  logic            load,
  input  logic [ST_W-1:0] ld_val,
  input  logic [ST_W-1:0] set_m,
  input  logic [ST_W-1:0] clr_m,
  input  logic            zn_upd,
  input  logic            z_in,
  input  logic            n_in,
  output logic [ST_W-1:0] st_q,
  output logic [ST_W-1:0] st_next
);
  always_comb begin
    if (warm_rst) begin
      st_next = (st_q | FORCE_MASK) & ~WARM_CLR;
    end else begin
      st_next = load ? ld_val : ((st_q | set_m) & ~clr_m);
      if (zn_upd) begin
        st_next[B_Z] = z_in;
        st_next[B_N] = n_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PWRON_ST;
    else     st_q <= st_next;
  end
endmodule

// File: rtl/rfu_gpr.sv
module rfu_gpr #(
  parameter int W        = 16,
  parameter int NW       = 8,
  parameter bit IS_INDEX = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  input  logic         trunc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (we) q <= din;
      if (IS_INDEX && trunc) q[W-1:NW] <= '0;
    end
  end
endmodule

// File: rtl/regflag_unit.sv
module regflag_unit
  import rfu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              st_load,
  input  logic [7:0]        st_val,
  input  logic [7:0]        st_set,
  input  logic [7:0]        st_clr,
  input  logic [7:0]        test_mask,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] idx_x_q,
  output logic [DATA_W-1:0] idx_y_q,
  output logic [7:0]        stat_q,
  output logic              test_hit
);
  localparam int NREG = 3;
  localparam int HI_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] reg_q [NREG];
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] merged;
  logic              narrow;
  logic              wz, wn;
  logic              wr_live;
  logic [ST_W-1:0]   st_q, st_next;

  assign wr_live = wr_en && (sel_e'(wr_sel) != SEL_NONE);

  always_comb begin
    case (sel_e'(wr_sel))
      SEL_ACC: begin cur_val = reg_q[0]; narrow = st_q[B_M]; end
      SEL_IX:  begin cur_val = reg_q[1]; narrow = st_q[B_X]; end
      SEL_IY:  begin cur_val = reg_q[2]; narrow = st_q[B_X]; end
      default: begin cur_val = '0;       narrow = 1'b1;      end
    endcase
  end

  rfu_write_merge #(.W(DATA_W), .NW(NARROW_W)) u_merge (
    .cur_hi  (cur_val[DATA_W-1:NARROW_W]),
    .din     (wr_val),
    .narrow  (narrow),
    .merged  (merged),
    .is_zero (wz),
    .is_neg  (wn)
  );

  rfu_status u_status (
    .clk      (clk),
    .rst      (rst),
    .warm_rst (warm_rst),
    .load     (st_load),
    .ld_val   (st_val),
    .set_m    (st_set),
    .clr_m    (st_clr),
    .zn_upd   (wr_live),
    .z_in     (wz),
    .n_in     (wn),
    .st_q     (st_q),
    .st_next  (st_next)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit IDX = (g != 0);
    logic we_g;
    assign we_g = wr_en && !warm_rst && (wr_sel == 2'(g));
    rfu_gpr #(.W(DATA_W), .NW(NARROW_W), .IS_INDEX(IDX)) u_gpr (
      .clk   (clk),
      .rst   (rst),
      .we    (we_g),
      .din   (merged),
      .trunc (st_next[B_X]),
      .q     (reg_q[g])
    );
  end

  assign acc_q    = reg_q[0];
  assign idx_x_q  = reg_q[1];
  assign idx_y_q  = reg_q[2];
  assign stat_q   = st_q;
  assign test_hit = ((st_q & test_mask) == test_mask);

  if (HI_W < 1) begin : g_bad_width
    initial $error("DATA_W must exceed NARROW_W");
  end
endmodule

// File: rtl/rfu_chk.sv
module rfu_chk #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          warm_rst,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          st_load,
  input logic [7:0]    st_clr,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] idx_x_q,
  input logic [DW-1:0] idx_y_q,
  input logic [7:0]    stat_q
);
  // R1
  por_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_q == 8'h34 && acc_q == '0 && idx_x_q == '0 && idx_y_q == '0));

  // R2
  warm_force_chk: assert property (@(posedge clk) disable iff (rst)
    warm_rst |=> (stat_q[2] && stat_q[4] && stat_q[5] && !stat_q[3] && $stable(acc_q)));

  // R3
  acc_hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && stat_q[5] && !warm_rst) |=> (acc_q[DW-1:NW] == $past(acc_q[DW-1:NW])));

  // R5
  acc_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && !warm_rst) |=>
      (stat_q[1] == ($past(stat_q[5]) ? (acc_q[NW-1:0] == '0) : (acc_q == '0))));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!warm_rst && !st_load && !wr_en) |=> ((stat_q & $past(st_clr)) == 8'h00));

  // R8
  idx_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[4] |-> (idx_x_q[DW-1:NW] == '0 && idx_y_q[DW-1:NW] == '0));
endmodule

bind regflag_unit rfu_chk #(.DW(DATA_W), .NW(NARROW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .warm_rst (warm_rst),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .st_load  (st_load),
  .st_clr   (st_clr),
  .acc_q    (acc_q),
  .idx_x_q  (idx_x_q),
  .idx_y_q  (idx_y_q),
  .stat_q   (stat_q)
);

// File: tb/sim_regflag_unit.sv
module sim_regflag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_val = 16'h0;
  logic        st_load = 1'b0;
  logic [7:0]  st_val = 8'h0;
  logic [7:0]  st_set = 8'h0;
  logic [7:0]  st_clr = 8'h0;
  logic [7:0]  test_mask = 8'h0;
  logic [15:0] acc_q, idx_x_q, idx_y_q;
  logic [7:0]  stat_q;
  logic        test_hit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mA, mX, mY;
  logic [7:0]  mP;

  always #(CLK_PERIOD/2) clk = ~clk;

  regflag_unit u0 (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_val(wr_val), .st_load(st_load), .st_val(st_val), .st_set(st_set),
    .st_clr(st_clr), .test_mask(test_mask), .acc_q(acc_q), .idx_x_q(idx_x_q),
    .idx_y_q(idx_y_q), .stat_q(stat_q), .test_hit(test_hit)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [7:0]  np;
    logic [15:0] old, nv, tv;
    bit          narrow;
    if (rst) begin
      mA = 0; mX = 0; mY = 0; mP = 8'h34;
    end else if (warm_rst) begin
      mP = (mP | 8'h34) & 8'hF7;
      mX = mX & 16'h00FF;
      mY = mY & 16'h00FF;
    end else begin
      np = st_load ? st_val : ((mP | st_set) & ~st_clr);
      if (wr_en && wr_sel != 2'd3) begin
        narrow = (wr_sel == 2'd0) ? mP[5] : mP[4];
        old = (wr_sel == 2'd0) ? mA : (wr_sel == 2'd1) ? mX : mY;
        nv = narrow ? ((old & 16'hFF00) | (wr_val & 16'h00FF)) : wr_val;
        tv = narrow ? (wr_val & 16'h00FF) : wr_val;
        np[1] = (tv == 0);
        np[7] = (tv != 0) && (narrow ? wr_val[7] : wr_val[15]);
        if (wr_sel == 2'd0) mA = nv;
        else if (wr_sel == 2'd1) mX = nv;
        else mY = nv;
      end
      if (np[4]) begin
        mX = mX & 16'h00FF;
        mY = mY & 16'h00FF;
      end
      mP = np;
    end
  endtask

  task automatic step(input string tag, input bit r, input bit w, input bit we, input logic [1:0] sel,
                      input logic [15:0] val, input bit ld, input logic [7:0] lv,
                      input logic [7:0] sm, input logic [7:0] cm, input logic [7:0] tm);
    rst = r; warm_rst = w; wr_en = we; wr_sel = sel; wr_val = val;
    st_load = ld; st_val = lv; st_set = sm; st_clr = cm; test_mask = tm;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "acc", acc_q, mA);
    chk(tag, "x", idx_x_q, mX);
    chk(tag, "y", idx_y_q, mY);
    chk(tag, "status", {8'h00, stat_q}, {8'h00, mP});
    chk(tag, "test_hit", {15'h0, test_hit}, {15'h0, ((mP & tm) == tm)});
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mA = 'x; mX = 'x; mY = 'x; mP = 'x;
    @(negedge clk);
    // R1 power-on values
    step("R1", 1, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h00, 8'h34);
    step("R1", 1, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    // R3 R5: narrow acc write keeps high byte, negative from bit 7
    step("R3", 0, 0, 1, 2'd0, 16'h12AB, 0, 8'h00, 8'h00, 8'h00, 8'h80);
    // R7 clear both width flags
    step("R7", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h30, 8'h30);
    // R5 wide write negative from bit 15
    step("R5", 0, 0, 1, 2'd0, 16'h8001, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R5", 0, 0, 1, 2'd0, 16'h0000, 0, 8'h00, 8'h00, 8'h00, 8'h02);
    step("R3", 0, 0, 1, 2'd0, 16'h7F00, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R7", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h20, 8'h00, 8'h20);
    // R3 R5 narrow zero low byte: zero flag despite nonzero high byte
    step("R3", 0, 0, 1, 2'd0, 16'hFF00, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    // R4 wide index writes
    step("R4", 0, 0, 1, 2'd1, 16'hBEEF, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R4", 0, 0, 1, 2'd2, 16'h1234, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    // R3 select 3 writes nothing
    step("R3", 0, 0, 1, 2'd3, 16'h0000, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    // R7 overlapping set and clear
    step("R7", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h41, 8'h01, 8'h40);
    // R9 mask tests
    step("R9", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R9", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h00, 8'h60);
    step("R9", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h00, 8'h61);
    // R6 R8 load with index-narrow truncates X and Y
    step("R6", 0, 0, 0, 2'd3, 16'h0, 1, 8'h10, 8'hFF, 8'h00, 8'h10);
    step("R8", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    // R4 narrow X write
    step("R4", 0, 0, 1, 2'd1, 16'hAA80, 0, 8'h00, 8'h00, 8'h00, 8'h80);
    // R10 wide write with same-cycle index-narrow set
    step("R6", 0, 0, 0, 2'd3, 16'h0, 1, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R10", 0, 0, 1, 2'd1, 16'hFFFF, 0, 8'h00, 8'h10, 8'h00, 8'h90);
    // R10 load plus write: write's zero/negative override loaded bits
    step("R10", 0, 0, 1, 2'd0, 16'h0000, 1, 8'h80, 8'h00, 8'h00, 8'h02);
    // R2 warm reset: prepare wide X, decimal set, then warm with ignored inputs
    step("R2", 0, 0, 0, 2'd3, 16'h0, 1, 8'h08, 8'h00, 8'h00, 8'h08);
    step("R2", 0, 0, 1, 2'd1, 16'h9999, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R2", 0, 0, 1, 2'd0, 16'hC3C3, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R2", 0, 1, 1, 2'd0, 16'h1111, 1, 8'h00, 8'h00, 8'hFF, 8'h34);
    // R1 power-on again
    step("R1", 1, 0, 1, 2'd0, 16'h5555, 0, 8'h00, 8'h00, 8'h00, 8'h34);
    step("R1", 0, 0, 0, 2'd3, 16'h0, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule